// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between a processor's data-memory load/store unit and two possible targets: a 4 KB on-chip RAM and an external memory bus. For every access it forms a 16-bit effective address and decides which target serves it. It also sets an enable for each byte of the external address, showing which address bytes the bus actually drives.

A short-form access has only an 8-bit pointer. It takes its upper address byte from a page register. A long-form access carries a full 16-bit data pointer. A 2-bit mapping mode selects one of four address maps:
- internal only, where the address wraps at 4 KB;
- split without bank select;
- split with bank select;
- external only.

In split mode without bank select, a short-form off-chip access leaves the upper address byte undriven, so that port latches elsewhere can supply it. Every decision is registered on the access strobe. The outputs form a one-cycle pulse in the cycle after the request.

Top module: `xmem_router`

## Requirements
- R1: An access presented with `acc_req` high at a rising edge produces its outputs in the next cycle only. In any cycle after an edge where `acc_req` was low, or during reset, every output is zero.
- R2: `ram_sel` and `xbus_stb` are never high in the same cycle. Exactly one of them is high in the cycle after an access.
- R3: When `acc_short`=1 the effective address is {`page_reg`, `ptr_lo`}. When `acc_short`=0 it is `dptr`.
- R4: With `map_mode`=2'b00 every access goes on-chip, and `ram_addr` is the effective address modulo 4096 (0x1000 and 0x2000 both give 0x000).
- R5: With `map_mode`=2'b01 or 2'b10, an effective address below 0x1000 goes on-chip with `ram_addr` = its low 12 bits. Any other address goes off-chip.
- R6: With `map_mode`=2'b01, a short-form off-chip access sets `xbus_lo_oe`=1 with `xbus_addr[7:0]`=`ptr_lo`, and sets `xbus_hi_oe`=0.
- R7: With `map_mode`=2'b01 or 2'b10, a long-form off-chip access drives all 16 bits: both enables are 1 and `xbus_addr`=`dptr`.
- R8: With `map_mode`=2'b10, a short-form off-chip access drives both bytes with `xbus_addr`={`page_reg`, `ptr_lo`}.
- R9: With `map_mode`=2'b11, every access goes off-chip with both enables high and the full effective address on `xbus_addr`.
- R10: An address byte whose enable is low reads as zero on `xbus_addr`. `ram_addr` is zero whenever `ram_sel` is low.
- R11: `ram_we` equals `acc_wr` for on-chip accesses, and `xbus_wr` equals `acc_wr` for off-chip accesses. Each is zero for the other target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 2 | Address map mode (00 int, 01 split/no bank, 10 split/bank, 11 ext) |
| page_reg | input | 8 | Upper address byte for short-form accesses |
| ptr_lo | input | 8 | 8-bit pointer value for short-form accesses |
| dptr | input | 16 | 16-bit pointer for long-form accesses |
| acc_req | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_short | input | 1 | 1 = short-form (8-bit pointer), 0 = long-form |
| ram_addr | output | 12 | On-chip RAM address |
| ram_sel | output | 1 | On-chip RAM select pulse |
| ram_we | output | 1 | On-chip RAM write |
| xbus_addr | output | 16 | External address bus value |
| xbus_hi_oe | output | 1 | Drive enable for xbus_addr[15:8] |
| xbus_lo_oe | output | 1 | Drive enable for xbus_addr[7:0] |
| xbus_stb | output | 1 | External access strobe pulse |
| xbus_wr | output | 1 | External write |

## Verification
The bench targets three corner cases.

The first is the split boundary at 0x0FFF/0x1000, for both access forms. A design with an off-by-one compare would send the last on-chip word off-chip, or send the first external word to RAM.

The second is wrap in internal-only mode at 0x1000 and 0x2000. A design that did not truncate would hand RAM an address out of range.

The third is a short-form off-chip access in split mode without bank select. A design that copied the bank-select behaviour would drive the page byte onto pins that port latches own. Random mixes of modes and forms, with idle gaps between them, catch strobes that overlap or linger past their cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    MAP_INT      = 2'b00,
    MAP_SPLIT_NB = 2'b01,
    MAP_SPLIT_BS = 2'b10,
    MAP_EXT      = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic onchip;
    logic hi_drv;
    logic lo_drv;
  } route_t;
endpackage

// File: rtl/xmem_ea_form.sv
module xmem_ea_form #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 8,
  localparam int PAGE_W = ADDR_W - PTR_W
) (
  input  logic [PAGE_W-1:0] page_reg,
  input  logic [PTR_W-1:0]  ptr_lo,
  input  logic [ADDR_W-1:0] dptr,
  input  logic              acc_short,
  output logic [ADDR_W-1:0] ea
);
  // short form: page register supplies the high part
  always_comb begin
    if (acc_short) ea = {page_reg, ptr_lo};
    else           ea = dptr;
  end
endmodule

// File: rtl/xmem_route_dec.sv
module xmem_route_dec
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ONCHIP_AW = 12
) (
  input  logic [1:0]        map_mode,
  input  logic              acc_short,
  input  logic [ADDR_W-1:0] ea,
  output route_t            route
);
  map_mode_e mode;
  logic      below;

  always_comb begin
    mode  = map_mode_e'(map_mode);
    below = (ea[ADDR_W-1:ONCHIP_AW] == '0);
    unique case (mode)
      MAP_INT:      route.onchip = 1'b1;
      MAP_SPLIT_NB,
      MAP_SPLIT_BS: route.onchip = below;
      default:      route.onchip = 1'b0;
    endcase
    route.lo_drv = !route.onchip;
    route.hi_drv = !route.onchip && !(mode == MAP_SPLIT_NB && acc_short);
  end
endmodule

// File: rtl/xmem_out_stage.sv
module xmem_out_stage
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 8,
  parameter int ONCHIP_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_req,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    ea,
  input  route_t               route,
  output logic [ONCHIP_AW-1:0] ram_addr,
  output logic                 ram_sel,
  output logic                 ram_we,
  output logic [ADDR_W-1:0]    xbus_addr,
  output logic                 xbus_hi_oe,
  output logic                 xbus_lo_oe,
  output logic                 xbus_stb,
  output logic                 xbus_wr
);
  always_ff @(posedge clk) begin
    if (rst || !acc_req) begin
      ram_addr   <= '0;
      ram_sel    <= 1'b0;
      ram_we     <= 1'b0;
      xbus_addr  <= '0;
      xbus_hi_oe <= 1'b0;
      xbus_lo_oe <= 1'b0;
      xbus_stb   <= 1'b0;
      xbus_wr    <= 1'b0;
    end else begin
      ram_sel    <= route.onchip;
      ram_we     <= route.onchip && acc_wr;
      ram_addr   <= route.onchip ? ea[ONCHIP_AW-1:0] : '0;
      xbus_stb   <= !route.onchip;
      xbus_wr    <= !route.onchip && acc_wr;
      xbus_hi_oe <= route.hi_drv;
      xbus_lo_oe <= route.lo_drv;
      xbus_addr  <= {route.hi_drv ? ea[ADDR_W-1:PTR_W] : {(ADDR_W-PTR_W){1'b0}},
                     route.lo_drv ? ea[PTR_W-1:0]      : {PTR_W{1'b0}}};
    end
  end
endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 8,
  parameter int ONCHIP_AW = 12,
  localparam int PAGE_W   = ADDR_W - PTR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           map_mode,
  input  logic [PAGE_W-1:0]    page_reg,
  input  logic [PTR_W-1:0]     ptr_lo,
  input  logic [ADDR_W-1:0]    dptr,
  input  logic                 acc_req,
  input  logic                 acc_wr,
  input  logic                 acc_short,
  output logic [ONCHIP_AW-1:0] ram_addr,
  output logic                 ram_sel,
  output logic                 ram_we,
  output logic [ADDR_W-1:0]    xbus_addr,
  output logic                 xbus_hi_oe,
  output logic                 xbus_lo_oe,
  output logic                 xbus_stb,
  output logic                 xbus_wr
);
  logic [ADDR_W-1:0] ea;
  route_t            route;

  xmem_ea_form #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ea (
    .page_reg(page_reg), .ptr_lo(ptr_lo), .dptr(dptr),
    .acc_short(acc_short), .ea(ea)
  );

  xmem_route_dec #(.ADDR_W(ADDR_W), .ONCHIP_AW(ONCHIP_AW)) u_dec (
    .map_mode(map_mode), .acc_short(acc_short), .ea(ea), .route(route)
  );

  xmem_out_stage #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .ONCHIP_AW(ONCHIP_AW)) u_out (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wr(acc_wr),
    .ea(ea), .route(route),
    .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we),
    .xbus_addr(xbus_addr), .xbus_hi_oe(xbus_hi_oe), .xbus_lo_oe(xbus_lo_oe),
    .xbus_stb(xbus_stb), .xbus_wr(xbus_wr)
  );
endmodule

// File: rtl/xmem_router_chk.sv
module xmem_router_chk #(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 8,
  parameter int ONCHIP_AW = 12,
  localparam int PAGE_W   = ADDR_W - PTR_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           map_mode,
  input logic                 acc_req,
  input logic                 acc_wr,
  input logic                 acc_short,
  input logic [ONCHIP_AW-1:0] ram_addr,
  input logic                 ram_sel,
  input logic                 ram_we,
  input logic [ADDR_W-1:0]    xbus_addr,
  input logic                 xbus_hi_oe,
  input logic                 xbus_lo_oe,
  input logic                 xbus_stb,
  input logic                 xbus_wr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_req |=> (!ram_sel && !xbus_stb && !xbus_hi_oe && !xbus_lo_oe));

  // R2
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && xbus_stb));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    acc_req |=> (ram_sel ^ xbus_stb));

  // R4
  int_onchip_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && map_mode == 2'b00) |=> ram_sel);

  // R6
  nb_short_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_short && map_mode == 2'b01) |=> !xbus_hi_oe);

  // R9
  ext_full_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && map_mode == 2'b11) |=> (xbus_stb && xbus_hi_oe && xbus_lo_oe));

  // R10
  undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!xbus_hi_oe |-> xbus_addr[ADDR_W-1:PTR_W] == '0) and
    (!xbus_lo_oe |-> xbus_addr[PTR_W-1:0] == '0) and
    (!ram_sel |-> ram_addr == '0));

  // R11
  wr_route_chk: assert property (@(posedge clk) disable iff (rst)
    acc_req |=> ((ram_we | xbus_wr) == $past(acc_wr)));
endmodule

bind xmem_router xmem_router_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .ONCHIP_AW(ONCHIP_AW)) u_chk (.*);

// File: tb/sim_xmem_router.sv
module sim_xmem_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  map_mode = '0;
  logic [7:0]  page_reg = '0, ptr_lo = '0;
  logic [15:0] dptr = '0;
  logic        acc_req = 1'b0, acc_wr = 1'b0, acc_short = 1'b0;
  logic [11:0] ram_addr;
  logic        ram_sel, ram_we, xbus_hi_oe, xbus_lo_oe, xbus_stb, xbus_wr;
  logic [15:0] xbus_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xmem_router u0 (.*);

  // {ram_sel, ram_we, ram_addr, xbus_stb, xbus_wr, hi_oe, lo_oe, xbus_addr}
  function automatic logic [33:0] model(input logic [1:0] m, input logic [7:0] pg,
      input logic [7:0] pl, input logic [15:0] dp, input logic sh, input logic wr);
    logic [15:0] ea;
    logic on, hi;
    ea = sh ? {pg, pl} : dp;
    on = (m == 2'b00) || ((m == 2'b01 || m == 2'b10) && ea < 16'h1000);
    hi = !on && !(m == 2'b01 && sh);
    return {on, on & wr, on ? ea[11:0] : 12'h0, !on, !on & wr, hi, !on,
            hi ? ea[15:8] : 8'h0, on ? 8'h0 : ea[7:0]};
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [33:0] e, input logic sh);
    if (m == 2'b00) return "R4";
    if (m == 2'b11) return "R9";
    if (e[33]) return "R5";
    if (sh) return (m == 2'b01) ? "R6" : "R8";
    return "R7";
  endfunction

  function automatic logic [33:0] outs();
    return {ram_sel, ram_we, ram_addr, xbus_stb, xbus_wr, xbus_hi_oe, xbus_lo_oe, xbus_addr};
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] m, input logic [7:0] pg, input logic [7:0] pl,
                        input logic [15:0] dp, input logic sh, input logic wr, input bit idle);
    logic [33:0] e;
    @(negedge clk);
    map_mode = m; page_reg = pg; ptr_lo = pl; dptr = dp; acc_short = sh; acc_wr = wr;
    acc_req = 1'b1;
    e = model(m, pg, pl, dp, sh, wr);
    @(negedge clk);
    acc_req = 1'b0;
    chk(tag_of(m, e, sh), outs(), e);
    // R2: never both targets
    total++;
    if (ram_sel && xbus_stb) begin bad++; $display("FAIL R2 act=both exp=one"); end
    // R11: write direction follows target
    chk("R11", {ram_we, xbus_wr}, {e[32], e[18]});
    if (idle) begin
      @(negedge clk);
      chk("R1", outs(), 34'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    acc_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", outs(), 34'h0);  // reset clears outputs even with a request
    rst = 1'b0; acc_req = 1'b0;
    @(negedge clk);
    chk("R1", outs(), 34'h0);
    // R4: wrap at 4 KB
    access(2'b00, 8'h00, 8'h00, 16'h1000, 1'b0, 1'b0, 1);
    chk("R4", {20'h0, ram_sel, 1'b0, ram_addr}, 34'h0);
    access(2'b00, 8'h00, 8'h00, 16'h2000, 1'b0, 1'b1, 0);
    access(2'b00, 8'h1F, 8'h34, 16'hFFFF, 1'b1, 1'b0, 0);
    // R3: short form uses page:ptr, ignores dptr
    access(2'b11, 8'hAB, 8'hCD, 16'h1234, 1'b1, 1'b0, 0);
    chk("R3", {18'h0, xbus_addr}, {18'h0, 16'hABCD});
    access(2'b11, 8'hAB, 8'hCD, 16'h1234, 1'b0, 1'b1, 0);
    chk("R3", {18'h0, xbus_addr}, {18'h0, 16'h1234});
    // R5 boundary
    access(2'b01, 8'h00, 8'h00, 16'h0FFF, 1'b0, 1'b1, 0);
    access(2'b01, 8'h00, 8'h00, 16'h1000, 1'b0, 1'b0, 1);
    access(2'b10, 8'h0F, 8'hFF, 16'h0000, 1'b1, 1'b0, 0);
    access(2'b10, 8'h10, 8'h00, 16'h0000, 1'b1, 1'b1, 0);
    // R6 / R10: upper byte left undriven
    access(2'b01, 8'h10, 8'h55, 16'h0000, 1'b1, 1'b1, 0);
    chk("R10", {17'h0, xbus_hi_oe, xbus_addr}, {17'h0, 1'b0, 16'h0055});
    access(2'b01, 8'h0F, 8'h55, 16'hFFFF, 1'b1, 1'b0, 1);
    access(2'b10, 8'h10, 8'h55, 16'h0000, 1'b1, 1'b0, 0);
    access(2'b11, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      logic [7:0]  pg;
      d  = 16'($urandom);
      pg = 8'($urandom);
      if (($urandom % 3) == 0) begin d[15:12] = 4'($urandom % 2); pg[7:4] = 4'($urandom % 2); end
      access(2'($urandom), pg, 8'($urandom), d, 1'($urandom), 1'($urandom),
             (($urandom % 4) == 0));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule